// File: doc/BRIEF.md
# Eight-Pin Low-Power I/O Register Port

This block is a small general-purpose I/O controller for eight pins, reached through a 32-bit word-addressed register bus. Software picks the direction of each pin, sets the level that output pins drive, and reads back the level that is actually on each pin after a two-stage synchroniser. Two write-only alias registers let software set or clear single output bits in one bus write, so no read-modify-write is needed.

A second requester, a DMA-style bus port, shares the register file with the CPU port. The DMA port is admitted only while the system-level low-power flag is high and software has set a DMA enable bit in the direction register. Any other DMA access is refused: it gets an acknowledge with an error flag and zero read data, and it changes nothing. When both ports ask in the same cycle, the CPU is served first and the DMA requester keeps its request up until it is served.

Both ports use a same-cycle handshake. A requester holds `req` and its command until `ack` is high; read data and the error flag are valid in that cycle, and a write takes effect at the clock edge that ends it.

Top module: `lp_gpio_port`

## Requirements
- R1: After reset every writable register is zero, so `pin_oe` and `pin_do` are 0 and the direction and output-data registers read 0.
- R2: Offset 0x00 is the direction register. Bit n (n = 0..7) set to 1 makes pin n a push-pull output and raises `pin_oe[n]`. Bit 31 is the DMA enable. Both read back as written.
- R3: Offset 0x04 holds output data in bits 7:0. `pin_do[n]` equals output-data bit n when pin n is an output and is 0 when pin n is an input.
- R4: Offset 0x08 is read-only and returns in bits 7:0 the `pin_in` level after two clock edges of synchronisation. Writes to it have no effect.
- R5: A write to offset 0x0C sets output-data bit n for each 1 in bit n (0..7) and clears it for each 1 in bit 16+n. Zero bits leave the output data unchanged.
- R6: When bit n and bit 16+n are both 1 in one write to 0x0C, output-data bit n becomes 1.
- R7: A write to offset 0x10 clears output-data bit n for each 1 in bit n (0..7), and leaves the other bits unchanged.
- R8: Reads of offsets 0x0C and 0x10 return zero.
- R9: When both ports request in the same cycle, `cpu_ack` is high and `dma_ack` is low. The DMA access is served in a later cycle, after the CPU request is gone.
- R10: A DMA access is performed, with the same effect as a CPU access, only while `lowpwr` is 1 and the DMA enable bit is 1.
- R11: A refused DMA access raises `dma_ack` and `dma_err` for that cycle, returns zero on `dma_rdata`, and changes no register.
- R12: Writes to unused bits or to offsets 0x14 to 0x1C have no effect, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lowpwr | input | 1 | System low-power indication |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 5 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, valid with ack |
| cpu_ack | output | 1 | CPU access served this cycle |
| dma_req | input | 1 | DMA access request, held until acknowledged |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 5 | DMA byte address |
| dma_wdata | input | 32 | DMA write data |
| dma_rdata | output | 32 | DMA read data, zero on refusal |
| dma_ack | output | 1 | DMA access served or refused this cycle |
| dma_err | output | 1 | DMA access refused this cycle |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_do | output | 8 | Per-pin output level |

## Verification
The hardest case to reach is a DMA request that collides with a CPU request and has to wait. The bench raises both requests on the same clock, with the DMA port admitted and both ports writing different values to the output data. It checks that only the CPU is acknowledged, then drops the CPU request while the DMA request stays up. The final output data must show the DMA value, which proves the DMA write was held and done second and not lost. Refusal is reached in two ways, with the low-power flag low and with the enable bit cleared, and each time the pins are checked to be unchanged.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    localparam int LPG_NPIN    = 8;
    localparam int LPG_DATA_W  = 32;
    localparam int LPG_ADDR_W  = 5;
    localparam int LPG_CLR_LSB = 16;
    localparam int LPG_DMA_BIT = 31;

    // word index taken from address bits [4:2]
    typedef enum logic [2:0] {
        OFS_MODE   = 3'd0,
        OFS_DOUT   = 3'd1,
        OFS_PIN    = 3'd2,
        OFS_SETCLR = 3'd3,
        OFS_CLR    = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic                  we;
        logic [LPG_ADDR_W-1:0] addr;
        logic [LPG_DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e word_sel(input logic [LPG_ADDR_W-1:0] a);
        return reg_sel_e'(a[LPG_ADDR_W-1:2]);
    endfunction

endpackage

// File: rtl/lpg_sync.sv
module lpg_sync #(
    parameter int NPIN   = lpg_pkg::LPG_NPIN,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] d,
    output logic [NPIN-1:0] q
);
    logic [NPIN-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lpg_arbiter.sv
module lpg_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic cpu_req,
    input  logic dma_req,
    input  logic lowpwr,
    input  logic dma_en,
    output logic cpu_gnt,
    output logic dma_gnt,
    output logic dma_refuse
);
    logic dma_turn;
    logic dma_allowed;

    assign dma_turn    = dma_req & ~cpu_req;
    assign dma_allowed = lowpwr & dma_en;
    assign cpu_gnt     = cpu_req;
    assign dma_gnt     = dma_turn & dma_allowed;
    assign dma_refuse  = dma_turn & ~dma_allowed;

    AST_GNT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_gnt, dma_gnt, dma_refuse}));                  // R9
    AST_DMA_GATE: assert property (@(posedge clk) disable iff (rst)
        dma_gnt |-> (lowpwr && dma_en));                            // R10
endmodule

// File: rtl/lpg_regfile.sv
module lpg_regfile
    import lpg_pkg::*;
#(
    parameter int NPIN = LPG_NPIN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc,
    input  bus_req_t              req,
    input  logic [NPIN-1:0]       pin_lvl,
    output logic [LPG_DATA_W-1:0] rdata,
    output logic [NPIN-1:0]       mode_q,
    output logic [NPIN-1:0]       dout_q,
    output logic                  dma_en_q
);
    reg_sel_e        sel;
    logic [NPIN-1:0] set_bits;
    logic [NPIN-1:0] clr_bits;
    logic            wr;
    logic            unused_bits;

    assign sel      = word_sel(req.addr);
    assign set_bits = req.wdata[NPIN-1:0];
    assign clr_bits = req.wdata[LPG_CLR_LSB +: NPIN];
    assign wr       = acc & req.we;
    assign unused_bits = ^{req.addr[1:0], req.wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            dout_q   <= '0;
            dma_en_q <= 1'b0;
        end else if (wr) begin
            case (sel)
                OFS_MODE: begin
                    mode_q   <= req.wdata[NPIN-1:0];
                    dma_en_q <= req.wdata[LPG_DMA_BIT];
                end
                OFS_DOUT:   dout_q <= req.wdata[NPIN-1:0];
                OFS_SETCLR: dout_q <= (dout_q & ~clr_bits) | set_bits;
                OFS_CLR:    dout_q <= dout_q & ~set_bits;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            OFS_MODE: begin
                rdata[NPIN-1:0]    = mode_q;
                rdata[LPG_DMA_BIT] = dma_en_q;
            end
            OFS_DOUT: rdata[NPIN-1:0] = dout_q;
            OFS_PIN:  rdata[NPIN-1:0] = pin_lvl;
            default:  rdata = '0;
        endcase
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == OFS_SETCLR && |(set_bits & clr_bits))
        |=> ((dout_q & $past(set_bits & clr_bits)) == $past(set_bits & clr_bits))); // R6
    AST_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == OFS_CLR) |=> ((dout_q & $past(set_bits)) == '0));             // R7
endmodule

// File: rtl/lp_gpio_port.sv
module lp_gpio_port
    import lpg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lowpwr,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [LPG_ADDR_W-1:0] cpu_addr,
    input  logic [LPG_DATA_W-1:0] cpu_wdata,
    output logic [LPG_DATA_W-1:0] cpu_rdata,
    output logic                  cpu_ack,
    input  logic                  dma_req,
    input  logic                  dma_we,
    input  logic [LPG_ADDR_W-1:0] dma_addr,
    input  logic [LPG_DATA_W-1:0] dma_wdata,
    output logic [LPG_DATA_W-1:0] dma_rdata,
    output logic                  dma_ack,
    output logic                  dma_err,
    input  logic [LPG_NPIN-1:0]   pin_in,
    output logic [LPG_NPIN-1:0]   pin_oe,
    output logic [LPG_NPIN-1:0]   pin_do
);
    logic                  cpu_gnt, dma_gnt, dma_refuse;
    logic                  dma_en;
    logic                  acc;
    bus_req_t              sel_req;
    logic [LPG_DATA_W-1:0] rdata;
    logic [LPG_NPIN-1:0]   mode_q, dout_q, pin_lvl;

    lpg_arbiter u_arb (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .dma_req(dma_req),
        .lowpwr(lowpwr), .dma_en(dma_en),
        .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .dma_refuse(dma_refuse)
    );

    lpg_sync #(.NPIN(LPG_NPIN), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_lvl)
    );

    always_comb begin
        if (cpu_gnt) sel_req = '{we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};
        else         sel_req = '{we: dma_we, addr: dma_addr, wdata: dma_wdata};
    end
    assign acc = cpu_gnt | dma_gnt;

    lpg_regfile #(.NPIN(LPG_NPIN)) u_regs (
        .clk(clk), .rst(rst), .acc(acc), .req(sel_req), .pin_lvl(pin_lvl),
        .rdata(rdata), .mode_q(mode_q), .dout_q(dout_q), .dma_en_q(dma_en)
    );

    assign cpu_ack   = cpu_gnt;
    assign cpu_rdata = cpu_gnt ? rdata : '0;
    assign dma_ack   = dma_gnt | dma_refuse;
    assign dma_err   = dma_refuse;
    assign dma_rdata = dma_gnt ? rdata : '0;
    assign pin_oe    = mode_q;
    assign pin_do    = dout_q & mode_q;

    AST_CPU_WINS: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && dma_req) |-> (cpu_ack && !dma_ack));                 // R9
    AST_REFUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        dma_err |-> (dma_rdata == '0 && dma_ack));                       // R11
    AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        dma_err |=> ($stable(pin_oe) && $stable(pin_do) && $stable(dma_en))); // R11
    AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pin_do & ~pin_oe) == '0);                                       // R3
endmodule

// File: tb/lp_gpio_port_tb_top.sv
module lp_gpio_port_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst, lowpwr;
    logic        cpu_req, cpu_we, dma_req, dma_we;
    logic [4:0]  cpu_addr, dma_addr;
    logic [31:0] cpu_wdata, dma_wdata, cpu_rdata, dma_rdata;
    logic        cpu_ack, dma_ack, dma_err;
    logic [7:0]  pin_in, pin_oe, pin_do;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lp_gpio_port dut_i (
        .clk(clk), .rst(rst), .lowpwr(lowpwr),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_ack(dma_ack),
        .dma_err(dma_err),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_do(pin_do)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // every task starts and ends at a falling edge
    task automatic cpu_wr(input logic [4:0] a, input logic [31:0] d);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [4:0] a, output logic [31:0] d);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #(CLK_P/4);
        d = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic dma_go(input logic w, input logic [4:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic ack, output logic err);
        dma_req = 1'b1; dma_we = w; dma_addr = a; dma_wdata = d;
        #(CLK_P/4);
        rd = dma_rdata; ack = dma_ack; err = dma_err;
        @(negedge clk);
        dma_req = 1'b0; dma_we = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 pin_oe", {24'd0, pin_oe}, 32'h0);
        chk("R1 pin_do", {24'd0, pin_do}, 32'h0);
        cpu_rd(5'h00, v); chk("R1 mode", v, 32'h0);
        cpu_rd(5'h04, v); chk("R1 dout", v, 32'h0);
    endtask

    task automatic t_mode;
        logic [31:0] v;
        cpu_wr(5'h00, 32'h8000_00A5);
        cpu_rd(5'h00, v); chk("R2 mode readback", v, 32'h8000_00A5);
        chk("R2 pin_oe", {24'd0, pin_oe}, 32'hA5);
        cpu_wr(5'h00, 32'h7FFF_FF00);
        cpu_rd(5'h00, v); chk("R12 mode unused bits", v, 32'h0);
    endtask

    task automatic t_dout;
        logic [31:0] v;
        cpu_wr(5'h00, 32'h0000_000F);
        cpu_wr(5'h04, 32'hFFFF_FFFF);
        cpu_rd(5'h04, v); chk("R3 dout readback", v, 32'hFF);
        chk("R3 pin_do masked", {24'd0, pin_do}, 32'h0F);
    endtask

    task automatic t_pin;
        logic [31:0] v;
        pin_in = 8'h3C;
        cpu_rd(5'h08, v); chk("R4 level after 0 edges", v, 32'h0);
        cpu_rd(5'h08, v); chk("R4 level after 1 edge", v, 32'h0);
        cpu_rd(5'h08, v); chk("R4 level after 2 edges", v, 32'h3C);
        cpu_wr(5'h08, 32'hFFFF_FFFF);
        cpu_rd(5'h08, v); chk("R4 write ignored", v, 32'h3C);
        cpu_rd(5'h04, v); chk("R4 dout untouched", v, 32'hFF);
    endtask

    task automatic t_setclr;
        logic [31:0] v;
        cpu_wr(5'h00, 32'h0000_00FF);
        cpu_wr(5'h04, 32'h0000_000F);
        cpu_wr(5'h0C, 32'h00F0_0030);
        cpu_rd(5'h04, v); chk("R6 set wins", v, 32'h3F);
        cpu_wr(5'h0C, 32'h0003_0080);
        cpu_rd(5'h04, v); chk("R5 set and clear", v, 32'hBC);
        cpu_wr(5'h0C, 32'h0000_0000);
        chk("R5 zero write no effect", {24'd0, pin_do}, 32'hBC);
        cpu_rd(5'h0C, v); chk("R8 setclr reads zero", v, 32'h0);
    endtask

    task automatic t_clr;
        logic [31:0] v;
        cpu_wr(5'h10, 32'h00FF_FF0C);
        cpu_rd(5'h04, v); chk("R7 clear only", v, 32'hB0);
        cpu_rd(5'h10, v); chk("R8 clr reads zero", v, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        cpu_wr(5'h14, 32'hFFFF_FFFF);
        cpu_wr(5'h1C, 32'h0000_0000);
        cpu_rd(5'h14, v); chk("R12 unmapped read", v, 32'h0);
        cpu_rd(5'h04, v); chk("R12 dout untouched", v, 32'hB0);
        cpu_rd(5'h00, v); chk("R12 mode untouched", v, 32'hFF);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        cpu_wr(5'h00, 32'h8000_00FF);
        lowpwr = 1'b1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 5'h04; cpu_wdata = 32'h55;
        dma_req = 1'b1; dma_we = 1'b1; dma_addr = 5'h04; dma_wdata = 32'hAA;
        #(CLK_P/4);
        chk("R9 cpu acked", {31'd0, cpu_ack}, 32'h1);
        chk("R9 dma waits", {31'd0, dma_ack}, 32'h0);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #(CLK_P/4);
        chk("R9 dma served next", {31'd0, dma_ack}, 32'h1);
        @(negedge clk);
        dma_req = 1'b0; dma_we = 1'b0;
        cpu_rd(5'h04, v); chk("R9 dma write landed last", v, 32'hAA);
    endtask

    task automatic t_dma_gate;
        logic [31:0] v;
        logic a, e;
        lowpwr = 1'b0;
        dma_go(1'b1, 5'h04, 32'h11, v, a, e);
        chk("R11 refused ack", {30'd0, a, e}, 32'h3);
        chk("R11 pins unchanged", {24'd0, pin_do}, 32'hAA);
        dma_go(1'b0, 5'h04, 32'h0, v, a, e);
        chk("R10 no access outside low power", {v[30:0], e}, {31'h0, 1'b1});
        lowpwr = 1'b1;
        dma_go(1'b0, 5'h04, 32'h0, v, a, e);
        chk("R10 admitted read", v, 32'hAA);
        chk("R10 admitted no error", {30'd0, a, e}, 32'h2);
        dma_go(1'b1, 5'h10, 32'h0F, v, a, e);
        chk("R10 admitted write", {24'd0, pin_do}, 32'hA0);
        cpu_wr(5'h00, 32'h0000_00FF);
        dma_go(1'b0, 5'h00, 32'h0, v, a, e);
        chk("R11 disabled read zero", v, 32'h0);
        chk("R11 disabled error", {31'd0, e}, 32'h1);
        dma_go(1'b1, 5'h00, 32'h8000_0000, v, a, e);
        cpu_rd(5'h00, v); chk("R11 mode unchanged", v, 32'hFF);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lowpwr = 1'b0; pin_in = 8'h00;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        dma_req = 1'b0; dma_we = 1'b0; dma_addr = '0; dma_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mode();
        t_dout();
        t_pin();
        t_setclr();
        t_clr();
        t_unmapped();
        t_priority();
        t_dma_gate();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule